// File: doc/BRIEF.md
# Ethernet Transmit Clock Generator

This block produces the transmit clock and the PHY reference clock for an Ethernet MAC from a single control register. All clocks are modelled as levels updated on a fast reference clock, with the two candidate source clocks given as enable strobes. The register holds several fields: a source select, a one-based integer divide value, a quarter-period transmit delay, a transmit clock gate, an RMII clock inversion, an RGMII/RMII mode bit and a master enable.

The selected source strobe drives a programmable divider. A toggle stage follows it, and that stage also applies the line-speed scaling. The result is a base clock at gigabit speed, and one five or fifty times slower at 100 or 10 Mbit/s. The rate follows the `linkSpeed` input with no register write.

The PHY reference output is the speed-scaled clock with no delay, gate or inversion. The transmit output passes through one of two paths. In RGMII mode it goes through a tapped delay line and the gate. In RMII mode it is taken directly, optionally inverted. Changes to the select, the divide value or the speed are deferred to a low phase of the clock, so that no shortened high pulse appears.

Top module: `eth_txclk_gen`

## Requirements
- R1: After reset the register is all zeros. Both `txClk` and `phyRefClk` are low and stay low until the register is written.
- R2: Register bits 9:7 hold a divide value N from 1 to 7. At gigabit speed the output period is 2*N selected source strobes. N = 0 behaves exactly like N = 1.
- R3: Register bit 4 picks the source strobe. When clear the divider counts `srcTick0`; when set it counts `srcTick1`.
- R4: `linkSpeed` scales the output period. 2'b10 and 2'b11 give x1 (gigabit), 2'b01 gives x5 (100 Mbit/s) and 2'b00 gives x50 (10 Mbit/s).
- R5: A new source select, divide value or speed takes effect only while the internal clock is low and at a divider count boundary. A high phase already in progress keeps its old length.
- R6: In RGMII mode, register bit 10 clear holds `txClk` low while `phyRefClk` keeps toggling.
- R7: Register bit 12 is the master enable. When it is clear, both `txClk` and `phyRefClk` are held low.
- R8: Register bit 0 set selects RGMII mode. In that mode, bits 6:5 hold a value d, and each `txClk` rising edge comes d*QUARTER_CYC reference cycles after the matching `phyRefClk` rising edge.
- R9: Register bit 0 clear selects RMII mode. In that mode the delay field and the gate bit have no effect: `txClk` rises in the same cycle as `phyRefClk` with the same period.
- R10: Register bit 11 set in RMII mode makes `txClk` the exact complement of `phyRefClk`. In RGMII mode bit 11 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 13 | Register write value |
| srcTick0 | input | 1 | Enable strobe of source clock 0 |
| srcTick1 | input | 1 | Enable strobe of source clock 1 |
| linkSpeed | input | 2 | Line speed code |
| txClk | output | 1 | Transmit clock level |
| phyRefClk | output | 1 | PHY reference clock level |

## Verification
The hardest case is a register write that lands in the middle of a high phase. This is the case where an immediate change would cut the pulse short. The stimulus first sets a long divide value. It waits for a `phyRefClk` rising edge observed at the ports, then writes a divide value of one two cycles later. The monitor measures the width of that same high pulse, which must keep the old length, and then measures the new short period. The delay taps are reached by measuring, at each delay setting, the cycle distance from a reference rising edge to the next transmit rising edge. The divide value is made large enough that every delay fits inside one half period.

// File: rtl/eth_txclk_pkg.sv
package eth_txclk_pkg;
  parameter int DIV_W      = 3;
  parameter int DLY_W      = 2;
  parameter int SPD_W      = 2;
  parameter int MODE_BIT   = 0;
  parameter int SEL_BIT    = 4;
  parameter int DLY_LO     = 5;
  parameter int DIV_LO     = 7;
  parameter int GATE_BIT   = 10;
  parameter int INV_BIT    = 11;
  parameter int MASTER_BIT = 12;
  parameter int REG_W      = MASTER_BIT + 1;

  typedef struct packed {
    logic             masterEn;
    logic             rgmii;
    logic             gateEn;
    logic             invRmii;
    logic             srcSel;
    logic [DIV_W-1:0] divN;
    logic [DLY_W-1:0] dlySel;
    logic [SPD_W-1:0] speed;
  } clkCtrlT;
endpackage

// File: rtl/eth_txclk_ctrl.sv
module eth_txclk_ctrl
  import eth_txclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [SPD_W-1:0] linkSpeed,
  input  logic             safePoint,
  input  logic             clkHigh,
  output clkCtrlT          cfg
);
  logic             regMaster, regRgmii, regGate, regInv, regSel;
  logic [DIV_W-1:0] regDiv;
  logic [DLY_W-1:0] regDly;
  logic             actSel;
  logic [DIV_W-1:0] actDiv;
  logic [SPD_W-1:0] actSpd;
  logic             unusedBits;

  assign unusedBits = ^wrData[SEL_BIT-1:MODE_BIT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regMaster <= 1'b0;
      regRgmii  <= 1'b0;
      regGate   <= 1'b0;
      regInv    <= 1'b0;
      regSel    <= 1'b0;
      regDiv    <= '0;
      regDly    <= '0;
    end else if (wrEn) begin
      regMaster <= wrData[MASTER_BIT];
      regRgmii  <= wrData[MODE_BIT];
      regGate   <= wrData[GATE_BIT];
      regInv    <= wrData[INV_BIT];
      regSel    <= wrData[SEL_BIT];
      regDiv    <= wrData[DIV_LO +: DIV_W];
      regDly    <= wrData[DLY_LO +: DLY_W];
    end
  end

  // Settings that shape the clock period move only at a safe low boundary
  always_comb begin
    cfg.masterEn = regMaster;
    cfg.rgmii    = regRgmii;
    cfg.gateEn   = regGate;
    cfg.invRmii  = regInv;
    cfg.dlySel   = regRgmii ? regDly : '0;
    cfg.srcSel   = safePoint ? regSel    : actSel;
    cfg.divN     = safePoint ? regDiv    : actDiv;
    cfg.speed    = safePoint ? linkSpeed : actSpd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= 1'b0;
      actDiv <= '0;
      actSpd <= '0;
    end else begin
      actSel <= cfg.srcSel;
      actDiv <= cfg.divN;
      actSpd <= cfg.speed;
    end
  end

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(actDiv) || !$stable(actSel) || !$stable(actSpd)) |-> !$past(clkHigh)); // R5
endmodule

// File: rtl/eth_txclk_path.sv
module eth_txclk_path
  import eth_txclk_pkg::*;
#(
  parameter int QUARTER_CYC = 2,
  parameter int MID_MULT    = 5,
  parameter int LOW_MULT    = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  clkCtrlT cfg,
  input  logic    srcTick0,
  input  logic    srcTick1,
  output logic    safePoint,
  output logic    clkHigh,
  output logic    txClk,
  output logic    phyRefClk
);
  localparam int CNT_W     = $clog2(LOW_MULT + 1);
  localparam int DLY_STEPS = 1 << DLY_W;
  localparam int DLY_DEPTH = (DLY_STEPS - 1) * QUARTER_CYC;

  logic [DIV_W-1:0]     divCnt;
  logic [DIV_W-1:0]     effN;
  logic                 tickSel, divWrap, spdWrap;
  logic [CNT_W-1:0]     spdCnt, mult;
  logic                 spdLevel;
  logic [DLY_DEPTH-1:0] dlyLine;
  logic [DLY_STEPS-1:0] taps;
  logic                 txNext;

  assign tickSel = cfg.srcSel ? srcTick1 : srcTick0;
  assign effN    = (cfg.divN == '0) ? DIV_W'(1) : cfg.divN;
  assign divWrap = tickSel && (divCnt >= effN - DIV_W'(1));

  always_comb begin
    case (cfg.speed)
      2'b01:   mult = CNT_W'(MID_MULT);
      2'b00:   mult = CNT_W'(LOW_MULT);
      default: mult = CNT_W'(1);
    endcase
  end

  assign spdWrap = divWrap && (spdCnt >= mult - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      spdCnt   <= '0;
      spdLevel <= 1'b0;
    end else begin
      if (tickSel) divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
      if (divWrap) spdCnt <= spdWrap ? '0 : spdCnt + CNT_W'(1);
      if (spdWrap) spdLevel <= ~spdLevel;
    end
  end

  assign safePoint = !spdLevel && (divCnt == '0);
  assign clkHigh   = spdLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyLine <= '0;
    else       dlyLine <= {dlyLine[DLY_DEPTH-2:0], spdLevel};
  end

  assign taps[0] = spdLevel;
  for (genvar gi = 1; gi < DLY_STEPS; gi++) begin : g_tap
    assign taps[gi] = dlyLine[gi*QUARTER_CYC-1];
  end

  assign txNext = cfg.rgmii ? (cfg.gateEn & taps[cfg.dlySel])
                            : (spdLevel ^ cfg.invRmii);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txClk     <= 1'b0;
      phyRefClk <= 1'b0;
    end else begin
      txClk     <= cfg.masterEn & txNext;
      phyRefClk <= cfg.masterEn & spdLevel;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> divCnt < $past(effN)); // R2
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.masterEn |=> (!txClk && !phyRefClk)); // R7
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.rgmii && !cfg.gateEn) |=> !txClk); // R6
  AST_RMII_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.masterEn && !cfg.rgmii) |=> (txClk == (phyRefClk ^ $past(cfg.invRmii)))); // R9
endmodule

// File: rtl/eth_txclk_gen.sv
module eth_txclk_gen
  import eth_txclk_pkg::*;
#(
  parameter int QUARTER_CYC = 2,
  parameter int MID_MULT    = 5,
  parameter int LOW_MULT    = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             srcTick0,
  input  logic             srcTick1,
  input  logic [SPD_W-1:0] linkSpeed,
  output logic             txClk,
  output logic             phyRefClk
);
  clkCtrlT cfg;
  logic    safePoint, clkHigh;

  eth_txclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .linkSpeed(linkSpeed), .safePoint(safePoint), .clkHigh(clkHigh), .cfg(cfg)
  );

  eth_txclk_path #(
    .QUARTER_CYC(QUARTER_CYC), .MID_MULT(MID_MULT), .LOW_MULT(LOW_MULT)
  ) u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .srcTick0(srcTick0), .srcTick1(srcTick1),
    .safePoint(safePoint), .clkHigh(clkHigh), .txClk(txClk), .phyRefClk(phyRefClk)
  );
endmodule

// File: tb/eth_txclk_gen_tb.sv
module eth_txclk_gen_tb;
  localparam int Q     = 2;
  localparam int LIMIT = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [12:0] wrData = '0;
  logic        srcTick0 = 1'b1;
  logic        srcTick1 = 1'b0;
  logic [1:0]  linkSpeed = 2'b10;
  logic        txClk, phyRefClk;

  int checks = 0;
  int fails  = 0;

  typedef struct { int kind; int expv; string tag; } expT;
  expT sbQ[$];
  event measReq, measDone;

  eth_txclk_gen #(.QUARTER_CYC(Q)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .srcTick0(srcTick0), .srcTick1(srcTick1), .linkSpeed(linkSpeed),
    .txClk(txClk), .phyRefClk(phyRefClk)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    srcTick1 = ~srcTick1;
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input bit master, input bit rgmii, input bit gate, input bit inv,
                    input bit sel, input logic [2:0] div, input logic [1:0] dly);
    @(negedge clk);
    wrEn   = 1'b1;
    wrData = '0;
    wrData[12]  = master;
    wrData[0]   = rgmii;
    wrData[10]  = gate;
    wrData[11]  = inv;
    wrData[4]   = sel;
    wrData[9:7] = div;
    wrData[6:5] = dly;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitTxRise(output int n);
    logic p;
    n = 0;
    p = txClk;
    forever begin
      @(negedge clk);
      n++;
      if (!p && txClk) break;
      p = txClk;
      if (n > LIMIT) begin n = -1; break; end
    end
  endtask

  task automatic waitRefRise(output bit txAlso, output bit ok);
    logic pr, pt;
    int n;
    pr = phyRefClk; pt = txClk; n = 0; ok = 1'b0; txAlso = 1'b0;
    while (n <= LIMIT) begin
      @(negedge clk);
      n++;
      if (!pr && phyRefClk) begin
        ok = 1'b1;
        txAlso = !pt && txClk;
        break;
      end
      pr = phyRefClk; pt = txClk;
    end
  endtask

  // monitor: pops expected items and measures the matching quantity
  initial forever begin
    expT e;
    int act;
    int n;
    bit txAlso, ok;
    @(measReq);
    e = sbQ.pop_front();
    act = -1;
    case (e.kind)
      0: begin
        waitTxRise(n);
        if (n >= 0) waitTxRise(act);
      end
      1: begin
        waitRefRise(txAlso, ok);
        if (ok) begin
          if (txAlso) act = 0;
          else waitTxRise(act);
        end
      end
      default: begin
        waitRefRise(txAlso, ok);
        if (ok) begin
          act = 1;
          forever begin
            @(negedge clk);
            if (phyRefClk && act < LIMIT) act++;
            else break;
          end
        end
      end
    endcase
    check(e.tag, act, e.expv);
    -> measDone;
  end

  task automatic expectItem(input int kind, input int expv, input string tag);
    expT e;
    e.kind = kind; e.expv = expv; e.tag = tag;
    sbQ.push_back(e);
    @(negedge clk);
    -> measReq;
    @(measDone);
  endtask

  task automatic countHigh(input int n, output int txH, output int refH, output int miss);
    txH = 0; refH = 0; miss = 0;
    repeat (n) begin
      @(negedge clk);
      if (txClk) txH++;
      if (phyRefClk) refH++;
      if (txClk == phyRefClk) miss++;
    end
  endtask

  initial begin
    int txH, refH, miss;
    bit txAlso, ok;
    settle(4);
    check("R1 reset txClk", int'(txClk), 0);
    check("R1 reset phyRefClk", int'(phyRefClk), 0);
    rstN = 1'b1;
    countHigh(40, txH, refH, miss);
    check("R1 idle after reset txClk high cycles", txH, 0);
    check("R1 idle after reset phyRefClk high cycles", refH, 0);

    wr(1, 1, 1, 0, 0, 3'd3, 2'd0); settle(30);
    expectItem(0, 6, "R2 div3 period");
    wr(1, 1, 1, 0, 0, 3'd0, 2'd0); settle(30);
    expectItem(0, 2, "R2 div0 acts as div1 period");
    wr(1, 1, 1, 0, 0, 3'd1, 2'd0); settle(30);
    expectItem(0, 2, "R2 div1 period");
    wr(1, 1, 1, 0, 0, 3'd7, 2'd0); settle(40);
    expectItem(0, 14, "R2 div7 period");

    wr(1, 1, 1, 0, 1, 3'd2, 2'd0); settle(40);
    expectItem(0, 8, "R3 source 1 div2 period");
    wr(1, 1, 1, 0, 0, 3'd2, 2'd0); settle(40);
    expectItem(0, 4, "R3 source 0 div2 period");

    wr(1, 1, 1, 0, 0, 3'd1, 2'd0);
    linkSpeed = 2'b01; settle(40);
    expectItem(0, 10, "R4 100M period");
    linkSpeed = 2'b00; settle(250);
    expectItem(0, 100, "R4 10M period");
    linkSpeed = 2'b11; settle(250);
    expectItem(0, 2, "R4 code 11 gigabit period");
    linkSpeed = 2'b10;

    wr(1, 1, 0, 0, 0, 3'd1, 2'd0); settle(10);
    countHigh(100, txH, refH, miss);
    check("R6 gate off txClk high cycles", txH, 0);
    check("R6 gate off phyRefClk keeps toggling", int'(refH > 0), 1);

    wr(0, 1, 1, 0, 0, 3'd1, 2'd0); settle(10);
    countHigh(100, txH, refH, miss);
    check("R7 master off txClk high cycles", txH, 0);
    check("R7 master off phyRefClk high cycles", refH, 0);

    for (int d = 0; d < 4; d++) begin
      wr(1, 1, 1, 0, 0, 3'd7, 2'(d)); settle(40);
      expectItem(1, d * Q, $sformatf("R8 delay step %0d offset", d));
    end

    wr(1, 0, 0, 0, 0, 3'd7, 2'd3); settle(40);
    expectItem(1, 0, "R9 rmii delay field ignored offset");
    expectItem(0, 14, "R9 rmii gate bit ignored period");

    wr(1, 0, 0, 1, 0, 3'd7, 2'd0); settle(40);
    countHigh(60, txH, refH, miss);
    check("R10 rmii invert txClk equals phyRefClk cycles", miss, 0);
    wr(1, 1, 1, 1, 0, 3'd7, 2'd2); settle(40);
    expectItem(1, 2 * Q, "R10 invert bit no effect in rgmii offset");

    // R5: shrink the divider in the middle of a high phase
    wr(1, 1, 1, 0, 0, 3'd7, 2'd0); settle(40);
    begin
      expT e;
      e.kind = 2; e.expv = 7; e.tag = "R5 high pulse width across divider change";
      sbQ.push_back(e);
      @(negedge clk);
      -> measReq;
      waitRefRise(txAlso, ok);
      settle(1);
      wr(1, 1, 1, 0, 0, 3'd1, 2'd0);
      @(measDone);
    end
    settle(20);
    expectItem(0, 2, "R5 new divider period after change");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule